// File: doc/BRIEF.md
# MSB-justified serial audio port

This block is the digital side of a stereo codec's audio serial interface. One serial port, driven by an external bit clock and word clock, carries two directions. Toward the host, it shifts the parallel left and right converter samples out as 16-bit words. From the host, it collects 16-bit words for the codec DAC. A second serial port, with its own bit and word clock pair, collects 18-bit words for an auxiliary DAC. Every word is two's complement and goes most significant bit first. The first bit of a word follows the word clock edge that opens its half-frame.

All serial inputs are brought into the system clock domain through a synchroniser chain. The block then works on the detected bit-clock edges. The word clock level selects the channel: high is left and low is right. A received stereo pair is presented as two parallel words with a one-cycle valid strobe. A force-zero input blanks the transmitted words. Each port also has a per-frame duty monitor. The monitor counts bit-clock periods in the high and low halves of the word clock. When the two halves differ by more than 5 % of the frame, it issues a one-cycle resynchronisation request.

Top module: `msbj_audio_port`

## Requirements
- R1: On port A the block captures, on bit-clock rising edges, a 16-bit MSB-first word in each half-frame. The half-frame with word clock high is presented on `dac_left` and the half-frame with it low on `dac_right`.
- R2: Bits beyond the word length in a half-frame (past 16 on port A, past 18 on port B) are ignored and do not alter the presented words.
- R3: `dac_valid` pulses high for exactly one clock once per frame, after the 16th bit of the right half-frame following a complete left half-frame. `dac_left` and `dac_right` change only in that cycle.
- R4: After each port A word clock edge, `sdo_a` carries the word for that channel MSB first. The word is `adc_left` for high and `adc_right` for low, as sampled at the edge. The MSB is valid before the first bit-clock rising edge, and each following bit appears after a bit-clock falling edge.
- R5: After the 16 data bits of a half-frame, `sdo_a` is 0 for the rest of that half-frame.
- R6: When `sdo_force_zero` is high at a port A word clock edge, the whole half-frame on `sdo_a` is 0.
- R7: Port B captures 18-bit MSB-first words in the same way. It presents them on `aux_left` and `aux_right`, with a one-cycle `aux_valid` pulse after the 18th bit of the right half-frame.
- R8: On port A, H is the number of bit-clock rising edges with word clock high in a frame and L the number with it low. A frame is judged faulty when |H-L|*20 > H+L. A faulty frame yields a one-cycle `resync_a` pulse at the first bit-clock rising edge of the next frame, and no pulse is produced otherwise. The first frame after reset is not judged.
- R9: Port B has its own duty monitor, built the same way as the R8 monitor, driving `resync_b`. It is independent of port A.
- R10: In and after reset, and before any frame arrives, `sdo_a`, `dac_valid`, `aux_valid`, `resync_a` and `resync_b` are 0, and all presented words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than four times the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_a | input | 1 | Port A bit clock |
| lrck_a | input | 1 | Port A word clock, high = left |
| sdi_a | input | 1 | Port A serial data toward the codec DAC |
| sdo_a | output | 1 | Port A serial data from the converter |
| adc_left | input | 16 | Left word to transmit |
| adc_right | input | 16 | Right word to transmit |
| sdo_force_zero | input | 1 | Blank transmitted words when high |
| dac_left | output | 16 | Received left word, port A |
| dac_right | output | 16 | Received right word, port A |
| dac_valid | output | 1 | One-cycle strobe for a new port A pair |
| bclk_b | input | 1 | Port B bit clock |
| lrck_b | input | 1 | Port B word clock, high = left |
| sdi_b | input | 1 | Port B serial data toward the auxiliary DAC |
| aux_left | output | 18 | Received left word, port B |
| aux_right | output | 18 | Received right word, port B |
| aux_valid | output | 1 | One-cycle strobe for a new port B pair |
| resync_a | output | 1 | Duty fault request, port A |
| resync_b | output | 1 | Duty fault request, port B |

## Verification
The bench sends half-frames longer than the word and fills the extra bits with random data. A receiver that failed to stop at the word length would shift the garbage in and corrupt the low bits. The duty limit is probed on both sides of the boundary. A 21/19 frame has a weighted difference exactly equal to the sum and must pass. A 22/18 frame and a 34/30 frame must fail. An inclusive compare, or one judging the wrong frame, would give the wrong count of requests. The transmit MSB is checked in the first bit slot, where a design that shifted on the falling edge coinciding with the word clock edge would lose it. The bench also checks blanking and the zero tail after bit 16, and keeps the 18-bit port's monitor apart from the 16-bit one.

// File: rtl/msbj_pkg.sv
// Shared constants and the duty-cycle test used by both port monitors.
package msbj_pkg;
    localparam int unsigned CODEC_WORD = 16;
    localparam int unsigned AUX_WORD   = 18;
    // Faulty when |high-low| * DUTY_RATIO exceeds high+low (5 % of frame).
    localparam int unsigned DUTY_RATIO = 20;

    // Returns 1 when the two half-frame lengths are too far apart.
    function automatic logic duty_bad(input logic [31:0] hi, input logic [31:0] lo);
        logic [31:0] diff;
        diff = (hi > lo) ? (hi - lo) : (lo - hi);
        return (diff * DUTY_RATIO) > (hi + lo);
    endfunction
endpackage

// File: rtl/msbj_sync.sv
// Multi-stage synchroniser for a group of slow serial inputs.
// Assumes the inputs change far slower than clk, so all bits of the group
// move through the chain together and keep their relative order.
module msbj_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] st [STAGES];

    // First stage: capture the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) st[0] <= '0;
        else        st[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Further stages: settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) st[g] <= '0;
            else        st[g] <= st[g-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/msbj_rx.sv
// MSB-justified receiver for one serial port and one word length.
// Samples data on detected bit-clock rising edges. A change of the word
// clock level at a rising edge opens a half-frame whose first bit is the MSB.
// Bits after WORD are dropped. A pair is released after the right word,
// and only when a left word completed before it.
// Assumes the word clock never moves at a bit-clock rising edge and WORD >= 2.
module msbj_rx #(
    parameter int WORD = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bclk,
    input  logic            lrck,
    input  logic            sdi,
    output logic [WORD-1:0] left_o,
    output logic [WORD-1:0] right_o,
    output logic            valid_o
);
    localparam int CW = $clog2(WORD + 1);
    localparam logic [CW-1:0] FULL = CW'(WORD);
    localparam logic [CW-1:0] LAST = CW'(WORD - 1);

    logic            bclk_q;
    logic            last_lr;
    logic            have_left;
    logic [CW-1:0]   cnt;
    logic [WORD-1:0] sh;
    logic [WORD-1:0] pend;
    logic [WORD-1:0] nxt;
    logic            rise;

    assign rise = bclk & ~bclk_q;
    assign nxt  = {sh[WORD-2:0], sdi};

    // Shift, count and release words on bit-clock rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q    <= 1'b0;
            last_lr   <= 1'b0;
            have_left <= 1'b0;
            cnt       <= FULL;
            sh        <= '0;
            pend      <= '0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            bclk_q  <= bclk;
            valid_o <= 1'b0;
            if (rise) begin
                last_lr <= lrck;
                if (lrck != last_lr) begin
                    sh  <= {{(WORD-1){1'b0}}, sdi};
                    cnt <= CW'(1);
                end else if (cnt < FULL) begin
                    sh  <= nxt;
                    cnt <= cnt + CW'(1);
                    if (cnt == LAST) begin
                        if (lrck) begin
                            pend      <= nxt;
                            have_left <= 1'b1;
                        end else if (have_left) begin
                            left_o    <= pend;
                            right_o   <= nxt;
                            valid_o   <= 1'b1;
                            have_left <= 1'b0;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/msbj_tx.sv
// MSB-justified transmitter. A word clock edge loads the channel word
// (zero when blanking), putting its MSB on the line at once. Each bit-clock
// falling edge shifts in a zero, so the line rests at 0 past the word.
// A load wins over a falling edge seen in the same cycle.
module msbj_tx #(
    parameter int WORD = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bclk,
    input  logic            lrck,
    input  logic [WORD-1:0] left_i,
    input  logic [WORD-1:0] right_i,
    input  logic            force_zero,
    output logic            sdo
);
    logic            bclk_q;
    logic            lr_q;
    logic [WORD-1:0] sh;
    logic            fall;
    logic            lr_chg;

    assign fall   = bclk_q & ~bclk;
    assign lr_chg = lrck ^ lr_q;

    // Load on word clock edges, shift on bit-clock falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            lr_q   <= 1'b0;
            sh     <= '0;
        end else begin
            bclk_q <= bclk;
            lr_q   <= lrck;
            if (lr_chg) begin
                if (force_zero) sh <= '0;
                else            sh <= lrck ? left_i : right_i;
            end else if (fall) begin
                sh <= {sh[WORD-2:0], 1'b0};
            end
        end
    end

    assign sdo = sh[WORD-1];
endmodule

// File: rtl/msbj_duty.sv
// Word clock duty monitor. Counts bit-clock rising edges in the high and
// low halves of each frame (a frame opens on a rising word clock). Judges
// the completed frame when the next one opens. The first frame after reset
// is only used to start counting. Counters saturate.
module msbj_duty #(
    parameter int CNT_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic lrck,
    output logic req_o
);
    logic             bclk_q;
    logic             last_lr;
    logic             started;
    logic [CNT_W-1:0] cnt_h;
    logic [CNT_W-1:0] cnt_l;
    logic             rise;
    logic             bad;

    assign rise = bclk & ~bclk_q;

    // Evaluate the tolerance rule on the finished frame's counts.
    always_comb bad = msbj_pkg::duty_bad(32'(cnt_h), 32'(cnt_l));

    // Count half-frame lengths and raise the request at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            last_lr <= 1'b0;
            started <= 1'b0;
            cnt_h   <= '0;
            cnt_l   <= '0;
            req_o   <= 1'b0;
        end else begin
            bclk_q <= bclk;
            req_o  <= 1'b0;
            if (rise) begin
                last_lr <= lrck;
                if (lrck && !last_lr) begin
                    req_o   <= started & bad;
                    started <= 1'b1;
                    cnt_h   <= CNT_W'(1);
                    cnt_l   <= '0;
                end else if (lrck) begin
                    if (cnt_h != '1) cnt_h <= cnt_h + CNT_W'(1);
                end else begin
                    if (cnt_l != '1) cnt_l <= cnt_l + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/msbj_audio_port.sv
// Stereo codec serial audio port. Port A: 16-bit transmit of the converter
// words plus 16-bit receive for the codec DAC. Port B: 18-bit receive for
// the auxiliary DAC on its own clock pair. Each port has a duty monitor.
// Assumes both bit clocks are slower than clk/4 and that word clock edges
// line up with bit-clock falling edges.
module msbj_audio_port #(
    parameter int CODEC_W     = msbj_pkg::CODEC_WORD,
    parameter int AUX_W       = msbj_pkg::AUX_WORD,
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bclk_a,
    input  logic               lrck_a,
    input  logic               sdi_a,
    output logic               sdo_a,
    input  logic [CODEC_W-1:0] adc_left,
    input  logic [CODEC_W-1:0] adc_right,
    input  logic               sdo_force_zero,
    output logic [CODEC_W-1:0] dac_left,
    output logic [CODEC_W-1:0] dac_right,
    output logic               dac_valid,
    input  logic               bclk_b,
    input  logic               lrck_b,
    input  logic               sdi_b,
    output logic [AUX_W-1:0]   aux_left,
    output logic [AUX_W-1:0]   aux_right,
    output logic               aux_valid,
    output logic               resync_a,
    output logic               resync_b
);
    logic [2:0] a_s;
    logic [2:0] b_s;

    msbj_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .d({bclk_a, lrck_a, sdi_a}), .q(a_s)
    );

    msbj_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .d({bclk_b, lrck_b, sdi_b}), .q(b_s)
    );

    msbj_rx #(.WORD(CODEC_W)) u_rx_a (
        .clk(clk), .rst_n(rst_n), .bclk(a_s[2]), .lrck(a_s[1]), .sdi(a_s[0]),
        .left_o(dac_left), .right_o(dac_right), .valid_o(dac_valid)
    );

    msbj_tx #(.WORD(CODEC_W)) u_tx_a (
        .clk(clk), .rst_n(rst_n), .bclk(a_s[2]), .lrck(a_s[1]),
        .left_i(adc_left), .right_i(adc_right), .force_zero(sdo_force_zero),
        .sdo(sdo_a)
    );

    msbj_duty #(.CNT_W(CNT_W)) u_duty_a (
        .clk(clk), .rst_n(rst_n), .bclk(a_s[2]), .lrck(a_s[1]), .req_o(resync_a)
    );

    msbj_rx #(.WORD(AUX_W)) u_rx_b (
        .clk(clk), .rst_n(rst_n), .bclk(b_s[2]), .lrck(b_s[1]), .sdi(b_s[0]),
        .left_o(aux_left), .right_o(aux_right), .valid_o(aux_valid)
    );

    msbj_duty #(.CNT_W(CNT_W)) u_duty_b (
        .clk(clk), .rst_n(rst_n), .bclk(b_s[2]), .lrck(b_s[1]), .req_o(resync_b)
    );
endmodule

// File: rtl/msbj_audio_port_chk.sv
// Property checker attached to the top module.
module msbj_audio_port_chk #(
    parameter int CODEC_W = 16,
    parameter int AUX_W   = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bclk_a,
    input logic               lrck_a,
    input logic               sdi_a,
    input logic               sdo_a,
    input logic [CODEC_W-1:0] adc_left,
    input logic [CODEC_W-1:0] adc_right,
    input logic               sdo_force_zero,
    input logic [CODEC_W-1:0] dac_left,
    input logic [CODEC_W-1:0] dac_right,
    input logic               dac_valid,
    input logic               bclk_b,
    input logic               lrck_b,
    input logic               sdi_b,
    input logic [AUX_W-1:0]   aux_left,
    input logic [AUX_W-1:0]   aux_right,
    input logic               aux_valid,
    input logic               resync_a,
    input logic               resync_b
);
    a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid);

    a_r3_words_move_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(dac_left) && $stable(dac_right)) |-> dac_valid);

    a_r7_aux_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        aux_valid |=> !aux_valid);

    a_r7_aux_words_move_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(aux_left) && $stable(aux_right)) |-> aux_valid);

    a_r8_resync_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        resync_a |=> !resync_a);

    a_r9_resync_b_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        resync_b |=> !resync_b);

    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sdo_a && !dac_valid && !aux_valid && !resync_a && !resync_b));
endmodule

bind msbj_audio_port msbj_audio_port_chk #(.CODEC_W(CODEC_W), .AUX_W(AUX_W)) i_chk (.*);

// File: tb/test_msbj_audio_port.sv
module test_msbj_audio_port;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_a = 1'b0, lrck_a = 1'b0, sdi_a = 1'b0;
    logic        sdo_a;
    logic [15:0] adc_left = '0, adc_right = '0;
    logic        sdo_force_zero = 1'b0;
    logic [15:0] dac_left, dac_right;
    logic        dac_valid;
    logic        bclk_b = 1'b0, lrck_b = 1'b0, sdi_b = 1'b0;
    logic [17:0] aux_left, aux_right;
    logic        aux_valid;
    logic        resync_a, resync_b;

    int checks = 0, failures = 0;
    int va_cnt = 0, vb_cnt = 0, ra_cnt = 0, rb_cnt = 0;
    int va_exp = 0, vb_exp = 0, ra_exp = 0, rb_exp = 0;
    int prev_ha = 0, prev_la = 0, prev_hb = 0, prev_lb = 0;
    bit have_a = 0, have_b = 0;
    logic [15:0] cap_dl, cap_dr;
    logic [17:0] cap_al, cap_ar;

    always #4 clk = ~clk;

    msbj_audio_port i_msbj_audio_port (.*);

    // Event monitors, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dac_valid) begin va_cnt++; cap_dl = dac_left; cap_dr = dac_right; end
            if (aux_valid) begin vb_cnt++; cap_al = aux_left; cap_ar = aux_right; end
            if (resync_a) ra_cnt++;
            if (resync_b) rb_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int bad(input int h, input int l);
        int d;
        d = (h > l) ? h - l : l - h;
        return (d * 20 > h + l) ? 1 : 0;
    endfunction

    task automatic bit_a(input bit lr, input bit din, output bit s);
        bclk_a = 1'b0; lrck_a = lr; sdi_a = din;
        repeat (HALF) @(negedge clk);
        s = sdo_a;
        bclk_a = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic half_a(input bit lr, input int n, input logic [15:0] w,
                          output logic [15:0] got, output bit extra);
        bit s;
        got = '0; extra = 0;
        for (int i = 0; i < n; i++) begin
            if (i < 16) begin
                bit_a(lr, w[15-i], s);
                got[15-i] = s;
            end else begin
                bit_a(lr, 1'($urandom % 2), s);
                extra = extra | s;
            end
        end
    endtask

    task automatic send_a(input int h, input int l, input logic [15:0] tl, input logic [15:0] tr,
                          input logic [15:0] dl, input logic [15:0] dr, input bit frc);
        logic [15:0] gl, gr, el, er;
        bit xl, xr;
        adc_left = tl; adc_right = tr; sdo_force_zero = frc;
        if (have_a) ra_exp += bad(prev_ha, prev_la);
        have_a = 1; prev_ha = h; prev_la = l;
        half_a(1'b1, h, dl, gl, xl);
        half_a(1'b0, l, dr, gr, xr);
        el = frc ? 16'h0 : tl;
        er = frc ? 16'h0 : tr;
        va_exp++;
        if (frc) begin
            chk(gl == 16'h0, "R6 forced left", 32'(gl), 32'h0);
            chk(gr == 16'h0, "R6 forced right", 32'(gr), 32'h0);
        end else begin
            chk(gl == el, "R4 sdo left", 32'(gl), 32'(el));
            chk(gr == er, "R4 sdo right", 32'(gr), 32'(er));
        end
        if (h > 16) chk(!xl, "R5 left tail", 32'(xl), 32'h0);
        if (l > 16) chk(!xr, "R5 right tail", 32'(xr), 32'h0);
        chk(va_cnt == va_exp, "R3 valid count", 32'(va_cnt), 32'(va_exp));
        chk(cap_dl == dl, "R1 R2 dac left", 32'(cap_dl), 32'(dl));
        chk(cap_dr == dr, "R1 R2 dac right", 32'(cap_dr), 32'(dr));
        chk(ra_cnt == ra_exp, "R8 resync count", 32'(ra_cnt), 32'(ra_exp));
    endtask

    task automatic half_b(input bit lr, input int n, input logic [17:0] w);
        for (int i = 0; i < n; i++) begin
            bclk_b = 1'b0; lrck_b = lr;
            sdi_b = (i < 18) ? w[17-i] : 1'($urandom % 2);
            repeat (HALF) @(negedge clk);
            bclk_b = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic send_b(input int h, input int l, input logic [17:0] dl, input logic [17:0] dr);
        if (have_b) rb_exp += bad(prev_hb, prev_lb);
        have_b = 1; prev_hb = h; prev_lb = l;
        half_b(1'b1, h, dl);
        half_b(1'b0, l, dr);
        vb_exp++;
        chk(vb_cnt == vb_exp, "R7 aux valid count", 32'(vb_cnt), 32'(vb_exp));
        chk(cap_al == dl, "R7 R2 aux left", 32'(cap_al), 32'(dl));
        chk(cap_ar == dr, "R7 R2 aux right", 32'(cap_ar), 32'(dr));
        chk(rb_cnt == rb_exp, "R9 resync_b count", 32'(rb_cnt), 32'(rb_exp));
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (10) @(negedge clk);
        // R10: reset state
        chk(sdo_a == 1'b0 && dac_valid == 1'b0 && aux_valid == 1'b0, "R10 outputs in reset",
            {29'h0, sdo_a, dac_valid, aux_valid}, 32'h0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(dac_left == 16'h0 && dac_right == 16'h0, "R10 dac words", 32'({dac_left, dac_right}), 32'h0);
        chk(aux_left == 18'h0 && aux_right == 18'h0, "R10 aux words", 32'(aux_left), 32'h0);
        chk(!resync_a && !resync_b && !sdo_a, "R10 quiet", {30'h0, resync_a, resync_b}, 32'h0);

        // Directed port A frames
        send_a(32, 32, 16'h8001, 16'h7FFE, 16'hA5C3, 16'h3C5A, 1'b0);
        send_a(32, 32, 16'hFFFF, 16'h0000, 16'h0001, 16'h8000, 1'b0);
        send_a(34, 30, 16'h1234, 16'hFEDC, 16'h7FFF, 16'hFFFF, 1'b0); // faulty (R8)
        send_a(32, 32, 16'hAAAA, 16'h5555, 16'h0F0F, 16'hF0F0, 1'b1); // blanked (R6)
        send_a(21, 19, 16'hC001, 16'h0003, 16'h1111, 16'h2222, 1'b0); // limit, passes (R8)
        send_a(22, 18, 16'h4002, 16'h8004, 16'h3333, 16'h4444, 1'b0); // just over (R8)
        send_a(32, 32, 16'h0F00, 16'h00F0, 16'h5A5A, 16'hA5A5, 1'b0);
        // Random port A frames with small duty skew
        for (int k = 0; k < 10; k++) begin
            send_a(32 + int'($urandom % 2), 32 + int'($urandom % 2),
                   16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                   1'($urandom % 4 == 0));
        end

        // Port B frames (18-bit)
        send_b(36, 36, 18'h2_0001, 18'h1_FFFE);
        send_b(40, 40, 18'h3_FFFF, 18'h0_0000);
        send_b(36, 44, 18'h1_5A5A, 18'h2_A5A5); // faulty (R9)
        send_b(40, 40, 18'h0_0001, 18'h2_0000);
        send_b(38, 38, 18'($urandom), 18'($urandom));
        // R9: port B faults must not reach port A's request
        chk(ra_cnt == ra_exp, "R9 independent of port A", 32'(ra_cnt), 32'(ra_exp));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule